// File: doc/BRIEF.md
# Split-Window Banked Video Memory Mapper

This block gives an 8-bit CPU a two-page view into a larger video store. A CPU address window two pages long is split at its midpoint. Each half has its own page-select register, so any two pages of the store can be seen at once. They may also be the same page. The page selects sit at two adjacent CPU addresses, and the CPU can read and write both. For a window access, the block takes the page select for the half being addressed and places it above the low offset bits to form the physical store address. Reads and writes use the same translation.

A second port is for the display side. It reads any physical address with one cycle of latency. It can run in the same cycle as a CPU access.

The page size is set by `PAGE_AW`:

| `PAGE_AW` | Page size | Window | Store |
|---|---|---|---|
| 12 | 4 KB | 0xC000–0xDFFF | 64 KB in sixteen pages |
| 8 (default) | 256 bytes | 0xC000–0xC1FF | 4 KB in sixteen pages |

The default keeps the elaborated store small. The bit that picks the half is always bit `PAGE_AW` of the window offset. All statements below use symbolic widths, with the default values given where a number is needed.

**Both request channels** use valid/ready. Ready is held high, so a request is taken in every cycle its valid is high. Neither response channel has a ready input. A response is valid for exactly one cycle, and the consumer must capture it in that cycle.

Top module: `vram_window_mapper`

## Requirements
- R1: After reset, both page selects read as 0, `bank_warn` is 0 and neither response valid is high. Both window halves therefore alias page 0: a byte written at 0xC005 reads back at 0xC105.
- R2: A window access at offset `o` from 0xC000 reaches physical address `{sel, o[PAGE_AW-1:0]}`. Here `sel` is the page select of the half chosen by `o[PAGE_AW]`. CPU reads and writes use this same translation.
- R3: The two halves translate independently. The lower half (`o[PAGE_AW]`=0) uses the select at 0xFF00. The upper half (`o[PAGE_AW]`=1) uses the select at 0xFF01.
- R4: A write to 0xFF00 or 0xFF01 stores only data bits 3:0. A read of either address returns the stored value in bits 3:0, with bits 7:4 zero.
- R5: A page-select write with any of data bits 7:4 set makes `bank_warn` go to 1. The flag stays at 1 until `warn_clr` is high in a cycle with no such write. If both happen in the same cycle, the flag stays set.
- R6: A CPU read of the window or of a page-select address gives `cpu_rsp_valid` high, with its data, in the cycle after the request. CPU writes, and accesses to any other address, give no response.
- R7: A display read request gives `vid_rsp_valid` and `vid_rsp_data` in the next cycle. In a cycle after one with no display request, `vid_rsp_valid` is 0.
- R8: If a CPU window write and a display read hit the same physical address in the same cycle, the write completes and the display read returns the data stored before that write.
- R9: A page-select write takes effect for a window access in the very next cycle.
- R10: A CPU write outside the window and outside 0xFF00–0xFF01 changes neither the store nor the page selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | CPU request ready (held high) |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | CPU_AW (16) | CPU byte address |
| cpu_req_wdata | input | DATA_W (8) | CPU write data |
| cpu_rsp_valid | output | 1 | CPU read data valid |
| cpu_rsp_rdata | output | DATA_W (8) | CPU read data |
| vid_req_valid | input | 1 | Display read request valid |
| vid_req_ready | output | 1 | Display request ready (held high) |
| vid_req_addr | input | BANK_W+PAGE_AW (12) | Physical store address |
| vid_rsp_valid | output | 1 | Display read data valid |
| vid_rsp_data | output | DATA_W (8) | Display read data |
| bank_warn | output | 1 | Sticky flag: a page-select write carried upper bits |
| warn_clr | input | 1 | Clears `bank_warn` |

## Verification
The CPU window write and the display read share one store, so they can fall in the same cycle. The bench provokes this by driving a CPU write and a display read of the same physical address on the same clock edge. The display response must carry the byte stored before that write. A second display read one cycle later must carry the new byte.

A page-select write immediately followed by a window access is the other same-edge hazard. It is judged by where the bytes land, read back through the display port.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WIN  = 2'd1,
    ACC_BSEL = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/vwm_decode.sv
module vwm_decode
  import vwm_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned PAGE_AW = 8,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hC000,
  parameter logic [CPU_AW-1:0] BSEL_BASE = 16'hFF00
) (
  input  logic [CPU_AW-1:0]  addr,
  output acc_kind_e          kind,
  output logic               half,
  output logic [PAGE_AW-1:0] offs,
  output logic               bsel_idx
);
  localparam logic [CPU_AW:0] SPAN = (CPU_AW+1)'(2 ** (PAGE_AW + 1));

  logic [CPU_AW:0] rel;
  logic            in_win;
  logic            in_bsel;

  always_comb begin
    rel     = {1'b0, addr} - {1'b0, WIN_BASE};
    in_win  = !rel[CPU_AW] && (rel < SPAN);
    in_bsel = (addr[CPU_AW-1:1] == BSEL_BASE[CPU_AW-1:1]);
    half     = rel[PAGE_AW];
    offs     = rel[PAGE_AW-1:0];
    bsel_idx = addr[0];
    if (in_win)       kind = ACC_WIN;
    else if (in_bsel) kind = ACC_BSEL;
    else              kind = ACC_NONE;
  end
endmodule

// File: rtl/vwm_bank_regs.sv
module vwm_bank_regs #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  warn_clr,
  output logic [1:0][BANK_W-1:0] banks,
  output logic                  warn
);
  logic overflow;
  assign overflow = |wr_data[DATA_W-1:BANK_W];

  for (genvar g = 0; g < 2; g++) begin : g_sel
    logic [BANK_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                       q <= '0;
      else if (wr_en && wr_idx == 1'(g)) q <= wr_data[BANK_W-1:0];
    end
    assign banks[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    warn <= 1'b0;
    else if (wr_en && overflow)    warn <= 1'b1;
    else if (warn_clr)             warn <= 1'b0;
  end
endmodule

// File: rtl/vwm_translate.sv
module vwm_translate #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned PAGE_AW = 8
) (
  input  logic [1:0][BANK_W-1:0]     banks,
  input  logic                       half,
  input  logic [PAGE_AW-1:0]         offs,
  output logic [BANK_W+PAGE_AW-1:0]  phys
);
  always_comb phys = {banks[half], offs};
endmodule

// File: rtl/vwm_store.sv
module vwm_store #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en && a_we)  mem[a_addr] <= a_wdata;
    if (a_en && !a_we) a_rdata <= mem[a_addr];
    if (b_en)          b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/vram_window_mapper.sv
module vram_window_mapper
  import vwm_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned PAGE_AW = 8,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hC000,
  parameter logic [CPU_AW-1:0] BSEL_BASE = 16'hFF00,
  localparam int unsigned PHYS_W = BANK_W + PAGE_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [CPU_AW-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              vid_req_valid,
  output logic              vid_req_ready,
  input  logic [PHYS_W-1:0] vid_req_addr,
  output logic              vid_rsp_valid,
  output logic [DATA_W-1:0] vid_rsp_data,
  output logic              bank_warn,
  input  logic              warn_clr
);
  acc_kind_e              kind;
  logic                   half;
  logic [PAGE_AW-1:0]     offs;
  logic                   bsel_idx;
  logic [1:0][BANK_W-1:0] banks;
  logic [PHYS_W-1:0]      phys;
  logic [DATA_W-1:0]      store_rdata;
  logic                   win_en;
  logic                   bsel_wr;
  logic                   rsp_q;
  logic                   rsp_bsel_q;
  logic [BANK_W-1:0]      bsel_rd_q;
  logic                   vid_rsp_q;

  assign cpu_req_ready = 1'b1;
  assign vid_req_ready = 1'b1;

  vwm_decode #(
    .CPU_AW(CPU_AW), .PAGE_AW(PAGE_AW),
    .WIN_BASE(WIN_BASE), .BSEL_BASE(BSEL_BASE)
  ) u_decode (
    .addr(cpu_req_addr), .kind(kind), .half(half),
    .offs(offs), .bsel_idx(bsel_idx)
  );

  assign win_en  = cpu_req_valid && (kind == ACC_WIN);
  assign bsel_wr = cpu_req_valid && cpu_req_we && (kind == ACC_BSEL);

  vwm_bank_regs #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bsel_wr), .wr_idx(bsel_idx),
    .wr_data(cpu_req_wdata), .warn_clr(warn_clr),
    .banks(banks), .warn(bank_warn)
  );

  vwm_translate #(.BANK_W(BANK_W), .PAGE_AW(PAGE_AW)) u_translate (
    .banks(banks), .half(half), .offs(offs), .phys(phys)
  );

  vwm_store #(.AW(PHYS_W), .DW(DATA_W)) u_store (
    .clk(clk),
    .a_en(win_en), .a_we(cpu_req_we), .a_addr(phys),
    .a_wdata(cpu_req_wdata), .a_rdata(store_rdata),
    .b_en(vid_req_valid), .b_addr(vid_req_addr), .b_rdata(vid_rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q      <= 1'b0;
      rsp_bsel_q <= 1'b0;
      bsel_rd_q  <= '0;
      vid_rsp_q  <= 1'b0;
    end else begin
      rsp_q      <= cpu_req_valid && !cpu_req_we && (kind != ACC_NONE);
      rsp_bsel_q <= (kind == ACC_BSEL);
      bsel_rd_q  <= banks[bsel_idx];
      vid_rsp_q  <= vid_req_valid;
    end
  end

  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = rsp_bsel_q ? DATA_W'(bsel_rd_q) : store_rdata;
  assign vid_rsp_valid = vid_rsp_q;
endmodule

// File: rtl/vwm_chk.sv
module vwm_chk #(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned PAGE_AW = 8,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hC000,
  parameter logic [CPU_AW-1:0] BSEL_BASE = 16'hFF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_we,
  input logic [CPU_AW-1:0] cpu_req_addr,
  input logic [DATA_W-1:0] cpu_req_wdata,
  input logic              cpu_rsp_valid,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              vid_req_valid,
  input logic              vid_rsp_valid,
  input logic              bank_warn,
  input logic              warn_clr
);
  localparam logic [CPU_AW:0] LO = {1'b0, WIN_BASE};
  localparam logic [CPU_AW:0] HI = LO + (CPU_AW+1)'(2 ** (PAGE_AW + 1));

  logic in_win, in_bsel, rd_hit, bad_bsel_wr;
  always_comb begin
    in_win      = ({1'b0, cpu_req_addr} >= LO) && ({1'b0, cpu_req_addr} < HI);
    in_bsel     = cpu_req_addr[CPU_AW-1:1] == BSEL_BASE[CPU_AW-1:1];
    rd_hit      = cpu_req_valid && !cpu_req_we && (in_win || in_bsel);
    bad_bsel_wr = cpu_req_valid && cpu_req_we && in_bsel && !in_win
                  && (|cpu_req_wdata[DATA_W-1:BANK_W]);
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bank_warn && !cpu_rsp_valid && !vid_rsp_valid));

  p_bsel_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !cpu_req_we && in_bsel && !in_win)
      |=> (cpu_rsp_rdata[DATA_W-1:BANK_W] == '0));

  p_warn_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_bsel_wr |=> bank_warn);

  p_warn_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_warn && !warn_clr) |=> bank_warn);

  p_warn_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_clr && !bad_bsel_wr) |=> !bank_warn);

  p_read_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> cpu_rsp_valid);

  p_no_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !cpu_rsp_valid);

  p_vid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req_valid |=> vid_rsp_valid);

  p_vid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_req_valid |=> !vid_rsp_valid);
endmodule

bind vram_window_mapper vwm_chk #(
  .CPU_AW(CPU_AW), .DATA_W(DATA_W), .BANK_W(BANK_W), .PAGE_AW(PAGE_AW),
  .WIN_BASE(WIN_BASE), .BSEL_BASE(BSEL_BASE)
) u_vwm_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid),
  .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
  .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
  .cpu_rsp_rdata(cpu_rsp_rdata), .vid_req_valid(vid_req_valid),
  .vid_rsp_valid(vid_rsp_valid), .bank_warn(bank_warn), .warn_clr(warn_clr)
);

// File: tb/test_vram_window_mapper.sv
`timescale 1ns/1ps
module test_vram_window_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_we = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic [7:0]  cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [7:0]  cpu_rsp_rdata;
  logic        vid_req_valid = 1'b0;
  logic        vid_req_ready;
  logic [11:0] vid_req_addr = '0;
  logic        vid_rsp_valid;
  logic [7:0]  vid_rsp_data;
  logic        bank_warn;
  logic        warn_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vram_window_mapper i_vram_window_mapper (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .vid_req_valid(vid_req_valid),
    .vid_req_ready(vid_req_ready), .vid_req_addr(vid_req_addr),
    .vid_rsp_valid(vid_rsp_valid), .vid_rsp_data(vid_rsp_data),
    .bank_warn(bank_warn), .warn_clr(warn_clr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [15:0] a, logic [7:0] d);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
  endtask

  task automatic cpu_rd(logic [15:0] a, output logic v, output logic [7:0] d);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = a;
    @(negedge clk);
    v = cpu_rsp_valid; d = cpu_rsp_rdata;
    cpu_req_valid = 1'b0;
  endtask

  task automatic vid_rd(logic [11:0] a, output logic [7:0] d);
    vid_req_valid = 1'b1; vid_req_addr = a;
    @(negedge clk);
    chk("R7 vid valid", 32'(vid_rsp_valid), 32'd1);
    d = vid_rsp_data;
    vid_req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic v; logic [7:0] d;
    chk("R1 warn", 32'(bank_warn), 0);
    chk("R1 cpu rsp", 32'(cpu_rsp_valid), 0);
    chk("R1 vid rsp", 32'(vid_rsp_valid), 0);
    cpu_rd(16'hFF00, v, d); chk("R1 sel0", 32'(d), 0);
    cpu_rd(16'hFF01, v, d); chk("R1 sel1", 32'(d), 0);
    cpu_wr(16'hC005, 8'hAA);
    cpu_rd(16'hC105, v, d); chk("R1 alias", 32'(d), 32'hAA);
  endtask

  task automatic t_translate();
    logic v; logic [7:0] d;
    cpu_wr(16'hFF00, 8'h03);
    cpu_wr(16'hFF01, 8'h09);
    cpu_wr(16'hC010, 8'h11);
    cpu_wr(16'hC120, 8'h22);
    vid_rd(12'h310, d); chk("R2 low half phys", 32'(d), 32'h11);
    vid_rd(12'h920, d); chk("R3 high half phys", 32'(d), 32'h22);
    cpu_rd(16'hC010, v, d); chk("R2 cpu read", 32'(d), 32'h11);
    chk("R6 read valid", 32'(v), 1);
    cpu_wr(16'hFF01, 8'h03);
    cpu_rd(16'hC110, v, d); chk("R3 same page", 32'(d), 32'h11);
  endtask

  task automatic t_bsel();
    logic v; logic [7:0] d;
    cpu_wr(16'hFF00, 8'hA7);
    chk("R5 warn set", 32'(bank_warn), 1);
    cpu_rd(16'hFF00, v, d); chk("R4 low bits only", 32'(d), 32'h07);
    chk("R6 bsel read valid", 32'(v), 1);
    cpu_wr(16'hFF01, 8'h02);
    chk("R5 sticky", 32'(bank_warn), 1);
    cpu_rd(16'hFF01, v, d); chk("R4 sel1", 32'(d), 32'h02);
    warn_clr = 1'b1; @(negedge clk); warn_clr = 1'b0;
    chk("R5 cleared", 32'(bank_warn), 0);
    warn_clr = 1'b1; cpu_wr(16'hFF01, 8'h12); warn_clr = 1'b0;
    chk("R5 set wins", 32'(bank_warn), 1);
    warn_clr = 1'b1; @(negedge clk); warn_clr = 1'b0;
    cpu_wr(16'hFF01, 8'h02);
    chk("R5 clean write", 32'(bank_warn), 0);
  endtask

  task automatic t_response();
    logic v; logic [7:0] d;
    cpu_wr(16'hC000, 8'h01);
    chk("R6 no rsp on write", 32'(cpu_rsp_valid), 0);
    cpu_rd(16'hE000, v, d); chk("R6 unmapped read", 32'(v), 0);
    cpu_rd(16'hBFFF, v, d); chk("R6 below window", 32'(v), 0);
    cpu_rd(16'hC200, v, d); chk("R6 above window", 32'(v), 0);
  endtask

  task automatic t_unmapped();
    logic v; logic [7:0] d;
    cpu_wr(16'hFF00, 8'h04);
    cpu_wr(16'hC000, 8'h66);
    cpu_wr(16'hC200, 8'h5A);
    cpu_wr(16'hBF00, 8'h5B);
    cpu_wr(16'hFF02, 8'h0F);
    cpu_rd(16'hC000, v, d); chk("R10 store kept", 32'(d), 32'h66);
    cpu_rd(16'hFF00, v, d); chk("R10 sel kept", 32'(d), 32'h04);
  endtask

  task automatic t_switch();
    logic [7:0] d;
    cpu_wr(16'hFF00, 8'h05);
    cpu_wr(16'hC030, 8'h77);
    cpu_wr(16'hFF00, 8'h06);
    cpu_wr(16'hC030, 8'h88);
    vid_rd(12'h530, d); chk("R9 old page", 32'(d), 32'h77);
    vid_rd(12'h630, d); chk("R9 new page", 32'(d), 32'h88);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = 16'hC030;
    cpu_req_wdata = 8'h99;
    vid_req_valid = 1'b1; vid_req_addr = 12'h630;
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0; vid_req_valid = 1'b0;
    chk("R8 old data", 32'(vid_rsp_data), 32'h88);
    chk("R7 collide valid", 32'(vid_rsp_valid), 1);
    @(negedge clk);
    chk("R7 idle", 32'(vid_rsp_valid), 0);
    vid_rd(12'h630, d); chk("R8 write landed", 32'(d), 32'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_bsel();
    t_response();
    t_unmapped();
    t_switch();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule